// File: doc/BRIEF.md
# Composite Video Line Blanking Sequencer

This block keeps track of where standard-definition composite video is, both as a line within the frame and as a field within the colour sequence. For each line it reports whether that line carries vertical sync, whether it is blanked, whether it is a blanked line free for vertical-interval data, and whether colour burst is sent. It handles four scan formats, selected by a two-bit input: 525-line and 625-line systems, each in interlaced and progressive (single-field) form. The 625-line interlaced format uses an eight-field sequence, and its line sets differ between field pairs.

A line-start strobe drives the block. Each strobe moves the line counter on by one, moves the field index on at field boundaries, and registers the flags for the new line. In master mode the counters run freely. In slave mode an external field-start input, sampled with the strobe, forces the counters back to the first line of the first field. Horizontal timing is produced elsewhere.

Top module: `vbi_line_seq`

## Requirements
- R1: Format codes are 0 = 525-line interlaced, 1 = 525-line progressive, 2 = 625-line interlaced and 3 = 625-line progressive. After reset the line number is 1. Each strobe adds one to it. The line after the last line of the frame is line 1, where the frame length is 525, 262, 625 or 312 for codes 0 to 3.
- R2: The field index is 1 after reset. It cycles 1 to 4 for codes 0 and 1, and 1 to 8 for codes 2 and 3. It steps forward when the line number becomes 1. For code 0 it also steps when the line becomes 264, and for code 2 when the line becomes 313.
- R3: Code 0: vsync is set on lines 1–9 and 264–272. The data flag is set on lines 10–21, 262–263, 273–284 and 525. Burst is off on lines 1–6, 261–269 and 523–525. Blank is set exactly where vsync or the data flag is set, and vsync and the data flag are never set together.
- R4: Code 1: vsync is set on lines 1–9 and the data flag on lines 10–21. Burst is off on lines 1–6 and 261–262. Blank is as in R3.
- R5: Code 2, field index 1, 2, 5 or 6: vsync is set on lines 1–6, 311–318 and 624–625. The data flag is set on lines 7–22 and 319–335. Burst is off on lines 1–6, 311–318 and 623–625. Blank is as in R3.
- R6: Code 2, field index 3, 4, 7 or 8: vsync is set on lines 1–5, 311–319 and 624–625. The data flag is set on lines 6–22 and 320–335. Burst is off on lines 1–5, 311–319 and 623–625. Blank is as in R3.
- R7: Code 3: vsync is set on lines 1–6 and 311–312, and the data flag on lines 7–22. Burst is off on lines 1–5 and 310–312. Blank is as in R3.
- R8: All outputs change only at the clock edge where the strobe is high, and are valid from the next cycle. While reset is applied they show line 1, field 1, vsync and blank set, the data flag clear and burst off.
- R9: In slave mode (master select low), a strobe with the external field-start input high takes the block to line 1, field 1, with the flags of line 1. A field-start pulse without a strobe changes nothing.
- R10: In master mode, the external field-start input has no effect.
- R11: After a change of format, the next strobe moves to line 1 if the current line is at or past the new frame length. It moves to field 1 if the current field index is above the new format's field count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_strobe | input | 1 | One-cycle pulse at the start of each line |
| fmt_sel | input | 2 | Scan format code (see R1) |
| master_mode | input | 1 | 1 = free-running, 0 = slave to field_start |
| ext_field_start | input | 1 | External field-start marker, sampled with the strobe in slave mode |
| line_num | output | 10 | Current line number, 1-based |
| field_idx | output | 4 | Current field in the colour sequence, 1-based |
| vsync_line | output | 1 | Line carries vertical sync pulses |
| blank_line | output | 1 | Line is blanked |
| vbi_line | output | 1 | Blanked line free for vertical-interval data |
| burst_en | output | 1 | Colour burst sent on this line |

## Verification
The hardest case to reach is the second field pair of the 625-line eight-field sequence, and the point where it changes pair at line 313. The bench reaches both by running the interlaced 625-line format through four full frames, 2500 strobes, and comparing every line against a model. A related case is a field index left above the 525-line range by a format change. To reach it, the bench advances 1562 lines into the 625-line sequence to field 6, then switches format before the next strobe.

// File: rtl/vbi_seq_pkg.sv
package vbi_seq_pkg;

    localparam int LINE_W = 10;
    localparam int PH_W   = 3;
    localparam int FLD_W  = 4;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [PH_W-1:0]   phase_t;

    typedef enum logic [1:0] {
        FMT_525_I = 2'd0,
        FMT_525_P = 2'd1,
        FMT_625_I = 2'd2,
        FMT_625_P = 2'd3
    } vfmt_e;

    typedef struct packed {
        logic vsync;
        logic blank;
        logic vbi;
        logic burst;
    } line_flags_t;

    localparam line_flags_t FLAGS_FIRST_LINE = '{vsync: 1'b1, blank: 1'b1, vbi: 1'b0, burst: 1'b0};

    function automatic line_t frame_len(vfmt_e f);
        case (f)
            FMT_525_I: return 10'd525;
            FMT_525_P: return 10'd262;
            FMT_625_I: return 10'd625;
            default:   return 10'd312;
        endcase
    endfunction

    // Line where the second field begins; zero when the format has one field per frame
    function automatic line_t second_field_line(vfmt_e f);
        case (f)
            FMT_525_I: return 10'd264;
            FMT_625_I: return 10'd313;
            default:   return '0;
        endcase
    endfunction

    function automatic phase_t last_phase(vfmt_e f);
        return (f == FMT_625_I || f == FMT_625_P) ? 3'd7 : 3'd3;
    endfunction

    function automatic logic in_span(line_t l, line_t lo, line_t hi);
        return (l >= lo) && (l <= hi);
    endfunction

    function automatic line_flags_t decode_flags(vfmt_e f, line_t l, phase_t ph);
        line_flags_t r;
        logic vs, dat, boff;
        vs = 1'b0; dat = 1'b0; boff = 1'b0;
        case (f)
            FMT_525_I: begin
                vs   = in_span(l, 10'd1, 10'd9) | in_span(l, 10'd264, 10'd272);
                dat  = in_span(l, 10'd10, 10'd21) | in_span(l, 10'd262, 10'd263)
                     | in_span(l, 10'd273, 10'd284) | (l == 10'd525);
                boff = in_span(l, 10'd1, 10'd6) | in_span(l, 10'd261, 10'd269)
                     | in_span(l, 10'd523, 10'd525);
            end
            FMT_525_P: begin
                vs   = in_span(l, 10'd1, 10'd9);
                dat  = in_span(l, 10'd10, 10'd21);
                boff = in_span(l, 10'd1, 10'd6) | in_span(l, 10'd261, 10'd262);
            end
            FMT_625_I: begin
                if (!ph[1]) begin
                    vs   = in_span(l, 10'd1, 10'd6) | in_span(l, 10'd311, 10'd318)
                         | in_span(l, 10'd624, 10'd625);
                    dat  = in_span(l, 10'd7, 10'd22) | in_span(l, 10'd319, 10'd335);
                    boff = in_span(l, 10'd1, 10'd6) | in_span(l, 10'd311, 10'd318)
                         | in_span(l, 10'd623, 10'd625);
                end else begin
                    vs   = in_span(l, 10'd1, 10'd5) | in_span(l, 10'd311, 10'd319)
                         | in_span(l, 10'd624, 10'd625);
                    dat  = in_span(l, 10'd6, 10'd22) | in_span(l, 10'd320, 10'd335);
                    boff = in_span(l, 10'd1, 10'd5) | in_span(l, 10'd311, 10'd319)
                         | in_span(l, 10'd623, 10'd625);
                end
            end
            default: begin
                vs   = in_span(l, 10'd1, 10'd6) | in_span(l, 10'd311, 10'd312);
                dat  = in_span(l, 10'd7, 10'd22);
                boff = in_span(l, 10'd1, 10'd5) | in_span(l, 10'd310, 10'd312);
            end
        endcase
        r.vsync = vs;
        r.vbi   = dat;
        r.blank = vs | dat;
        r.burst = ~boff;
        return r;
    endfunction

endpackage

// File: rtl/vbi_line_ctr.sv
module vbi_line_ctr
    import vbi_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  logic  resync,
    input  vfmt_e fmt,
    output line_t line_q,
    output line_t line_next
);

    line_t len;

    always_comb begin
        len = frame_len(fmt);
        if (resync)
            line_next = line_t'(1);
        else if (line_q >= len)
            line_next = line_t'(1);
        else
            line_next = line_q + line_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            line_q <= line_t'(1);
        else if (adv)
            line_q <= line_next;
    end

endmodule

// File: rtl/vbi_field_ctr.sv
module vbi_field_ctr
    import vbi_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    input  logic   resync,
    input  vfmt_e  fmt,
    input  line_t  line_next,
    output phase_t phase_q,
    output phase_t phase_next
);

    line_t  sec;
    phase_t last;
    logic   boundary;

    always_comb begin
        sec      = second_field_line(fmt);
        last     = last_phase(fmt);
        boundary = (line_next == line_t'(1)) || ((sec != '0) && (line_next == sec));
        if (resync)
            phase_next = '0;
        else if (phase_q > last)
            phase_next = '0;
        else if (boundary)
            phase_next = (phase_q == last) ? '0 : phase_q + phase_t'(1);
        else
            phase_next = phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (adv)
            phase_q <= phase_next;
    end

endmodule

// File: rtl/vbi_flag_reg.sv
module vbi_flag_reg
    import vbi_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        adv,
    input  vfmt_e       fmt,
    input  line_t       line_next,
    input  phase_t      phase_next,
    output line_flags_t flags_q
);

    line_flags_t flags_d;

    always_comb flags_d = decode_flags(fmt, line_next, phase_next);

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= FLAGS_FIRST_LINE;
        else if (adv)
            flags_q <= flags_d;
    end

endmodule

// File: rtl/vbi_line_seq.sv
module vbi_line_seq
    import vbi_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_strobe,
    input  logic [1:0]       fmt_sel,
    input  logic             master_mode,
    input  logic             ext_field_start,
    output logic [LINE_W-1:0] line_num,
    output logic [FLD_W-1:0]  field_idx,
    output logic             vsync_line,
    output logic             blank_line,
    output logic             vbi_line,
    output logic             burst_en
);

    vfmt_e       fmt;
    logic        resync;
    line_t       line_q, line_next;
    phase_t      phase_q, phase_next;
    line_flags_t flags_q;

    assign fmt    = vfmt_e'(fmt_sel);
    assign resync = line_strobe & ~master_mode & ext_field_start;

    vbi_line_ctr u_line (
        .clk       (clk),
        .rst       (rst),
        .adv       (line_strobe),
        .resync    (resync),
        .fmt       (fmt),
        .line_q    (line_q),
        .line_next (line_next)
    );

    vbi_field_ctr u_field (
        .clk        (clk),
        .rst        (rst),
        .adv        (line_strobe),
        .resync     (resync),
        .fmt        (fmt),
        .line_next  (line_next),
        .phase_q    (phase_q),
        .phase_next (phase_next)
    );

    vbi_flag_reg u_flags (
        .clk        (clk),
        .rst        (rst),
        .adv        (line_strobe),
        .fmt        (fmt),
        .line_next  (line_next),
        .phase_next (phase_next),
        .flags_q    (flags_q)
    );

    assign line_num   = line_q;
    assign field_idx  = FLD_W'(phase_q) + FLD_W'(1);
    assign vsync_line = flags_q.vsync;
    assign blank_line = flags_q.blank;
    assign vbi_line   = flags_q.vbi;
    assign burst_en   = flags_q.burst;

endmodule

// File: rtl/vbi_line_seq_chk.sv
module vbi_line_seq_chk
    import vbi_seq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             line_strobe,
    input logic [1:0]       fmt_sel,
    input logic             master_mode,
    input logic             ext_field_start,
    input logic [LINE_W-1:0] line_num,
    input logic [FLD_W-1:0]  field_idx,
    input logic             vsync_line,
    input logic             blank_line,
    input logic             vbi_line,
    input logic             burst_en
);

    // R1
    line_step_chk: assert property (@(posedge clk) disable iff (rst)
        (line_strobe && master_mode && line_num < 10'd262) |=> (line_num == $past(line_num) + 10'd1));

    // R1
    line_range_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(line_strobe) && $stable(fmt_sel)) |->
        (line_num != '0 && line_num <= frame_len(vfmt_e'(fmt_sel))));

    // R2
    field_range_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(line_strobe) && $stable(fmt_sel) && !fmt_sel[1]) |-> (field_idx >= 4'd1 && field_idx <= 4'd4));

    // R3
    sync_data_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(vsync_line && vbi_line));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(line_strobe) |-> ($stable(line_num) && $stable(field_idx) && $stable(vsync_line)
                                 && $stable(blank_line) && $stable(vbi_line) && $stable(burst_en)));

    // R9
    resync_chk: assert property (@(posedge clk) disable iff (rst)
        (line_strobe && !master_mode && ext_field_start) |=>
        (line_num == 10'd1 && field_idx == 4'd1 && vsync_line && !burst_en));

endmodule

bind vbi_line_seq vbi_line_seq_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .line_strobe     (line_strobe),
    .fmt_sel         (fmt_sel),
    .master_mode     (master_mode),
    .ext_field_start (ext_field_start),
    .line_num        (line_num),
    .field_idx       (field_idx),
    .vsync_line      (vsync_line),
    .blank_line      (blank_line),
    .vbi_line        (vbi_line),
    .burst_en        (burst_en)
);

// File: tb/sim_vbi_line_seq.sv
module sim_vbi_line_seq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_strobe = 1'b0;
    logic [1:0] fmt_sel = 2'd0;
    logic       master_mode = 1'b1;
    logic       ext_field_start = 1'b0;
    logic [9:0] line_num;
    logic [3:0] field_idx;
    logic       vsync_line, blank_line, vbi_line, burst_en;

    int checks = 0;
    int errors = 0;
    int el = 1;
    int ef = 1;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbi_line_seq u0 (
        .clk(clk), .rst(rst), .line_strobe(line_strobe), .fmt_sel(fmt_sel),
        .master_mode(master_mode), .ext_field_start(ext_field_start),
        .line_num(line_num), .field_idx(field_idx), .vsync_line(vsync_line),
        .blank_line(blank_line), .vbi_line(vbi_line), .burst_en(burst_en)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d (line %0d field %0d)", req, what, got, exp, el, ef);
        end
    endtask

    function automatic int r(int l, int a, int b);
        return (l >= a && l <= b) ? 1 : 0;
    endfunction

    function automatic int flen(int f);
        return f == 0 ? 525 : f == 1 ? 262 : f == 2 ? 625 : 312;
    endfunction

    function automatic string freq(int f, int fld);
        if (f == 0) return "R3";
        if (f == 1) return "R4";
        if (f == 3) return "R7";
        return (fld == 3 || fld == 4 || fld == 7 || fld == 8) ? "R6" : "R5";
    endfunction

    task automatic model(input int f, input int l, input int fld, output int vs, output int dat, output int bu);
        int off;
        bit pair_b;
        pair_b = (fld == 3 || fld == 4 || fld == 7 || fld == 8);
        vs = 0; dat = 0; off = 0;
        if (f == 0) begin
            vs  = r(l,1,9) | r(l,264,272);
            dat = r(l,525,525) | r(l,10,21) | r(l,262,263) | r(l,273,284);
            off = r(l,1,6) | r(l,261,269) | r(l,523,525);
        end else if (f == 1) begin
            vs = r(l,1,9); dat = r(l,10,21); off = r(l,1,6) | r(l,261,262);
        end else if (f == 2 && !pair_b) begin
            vs  = r(l,1,6) | r(l,311,318) | r(l,624,625);
            dat = r(l,7,22) | r(l,319,335);
            off = r(l,1,6) | r(l,311,318) | r(l,623,625);
        end else if (f == 2) begin
            vs  = r(l,1,5) | r(l,311,319) | r(l,624,625);
            dat = r(l,6,22) | r(l,320,335);
            off = r(l,1,5) | r(l,311,319) | r(l,623,625);
        end else begin
            vs = r(l,1,6) | r(l,311,312); dat = r(l,7,22); off = r(l,1,5) | r(l,310,312);
        end
        bu = off ? 0 : 1;
    endtask

    task automatic step_model(input int f);
        int cnt, sec;
        cnt = (f >= 2) ? 8 : 4;
        sec = (f == 0) ? 264 : (f == 2) ? 313 : 0;
        el = (el >= flen(f)) ? 1 : el + 1;
        if (ef > cnt) ef = 1;
        else if (el == 1 || (sec != 0 && el == sec)) ef = (ef >= cnt) ? 1 : ef + 1;
    endtask

    task automatic check_all(input int f, input string tag);
        int vs, dat, bu;
        model(f, el, ef, vs, dat, bu);
        chk("R1", {tag, " line"}, int'(line_num), el);
        chk("R2", {tag, " field"}, int'(field_idx), ef);
        chk(freq(f, ef), {tag, " vsync"}, int'(vsync_line), vs);
        chk(freq(f, ef), {tag, " blank"}, int'(blank_line), vs | dat);
        chk(freq(f, ef), {tag, " vbi"}, int'(vbi_line), dat);
        chk(freq(f, ef), {tag, " burst"}, int'(burst_en), bu);
    endtask

    task automatic pulse(input bit ext);
        @(negedge clk);
        line_strobe = 1'b1;
        ext_field_start = ext;
        @(negedge clk);
        line_strobe = 1'b0;
        ext_field_start = 1'b0;
    endtask

    task automatic do_reset(input int f, input bit master);
        @(negedge clk);
        rst = 1'b1;
        fmt_sel = 2'(f);
        master_mode = master;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", "reset line", int'(line_num), 1);
        chk("R8", "reset vsync", int'(vsync_line), 1);
        chk("R8", "reset burst", int'(burst_en), 0);
        rst = 1'b0;
        el = 1; ef = 1;
        @(negedge clk);
        check_all(f, "after reset");
    endtask

    task automatic advance(input int f, input int n, input bit check_each);
        for (int i = 0; i < n; i++) begin
            pulse(1'b0);
            step_model(f);
            if (check_each) check_all(f, "sweep");
        end
    endtask

    // R1 R2 R3 R4 R5 R6 R7: full sequence sweeps
    task automatic t_sweep(input int f, input int n);
        do_reset(f, 1'b1);
        advance(f, n, 1'b1);
        chk("R2", "sequence returns to field 1", int'(field_idx), 1);
    endtask

    // R8: update timing and hold
    task automatic t_timing();
        do_reset(0, 1'b1);
        @(negedge clk);
        line_strobe = 1'b1;
        #(CLK_PERIOD/4);
        chk("R8", "no change before edge", int'(line_num), 1);
        @(negedge clk);
        line_strobe = 1'b0;
        el = 2;
        chk("R8", "updated after edge", int'(line_num), 2);
        repeat (4) @(negedge clk);
        chk("R8", "held without strobe", int'(line_num), 2);
        chk("R8", "flags held", int'(vsync_line), 1);
    endtask

    // R9: slave resync
    task automatic t_slave();
        do_reset(2, 1'b0);
        advance(2, 700, 1'b0);
        check_all(2, "slave pre");
        @(negedge clk);
        ext_field_start = 1'b1;
        repeat (3) @(negedge clk);
        ext_field_start = 1'b0;
        chk("R9", "pulse without strobe", int'(line_num), el);
        pulse(1'b1);
        el = 1; ef = 1;
        chk("R9", "resync line", int'(line_num), 1);
        chk("R9", "resync field", int'(field_idx), 1);
        chk("R9", "resync vsync", int'(vsync_line), 1);
        check_all(2, "R9 resync");
        advance(2, 6, 1'b1);
    endtask

    // R10: master ignores field start
    task automatic t_master();
        do_reset(0, 1'b1);
        advance(0, 40, 1'b0);
        pulse(1'b1);
        step_model(0);
        chk("R10", "line keeps counting", int'(line_num), 42);
        check_all(0, "R10 master");
    endtask

    // R11: format change
    task automatic t_fmt_change();
        do_reset(2, 1'b1);
        advance(2, 1562, 1'b0);
        chk("R11", "reach line 313", int'(line_num), 313);
        chk("R11", "reach field 6", int'(field_idx), 6);
        fmt_sel = 2'd0;
        pulse(1'b0);
        step_model(0);
        chk("R11", "field wraps to 1", int'(field_idx), 1);
        check_all(0, "R11 fmt 0");
        do_reset(2, 1'b1);
        advance(2, 399, 1'b0);
        chk("R11", "reach line 400", int'(line_num), 400);
        fmt_sel = 2'd1;
        pulse(1'b0);
        step_model(1);
        chk("R11", "line wraps to 1", int'(line_num), 1);
        check_all(1, "R11 fmt 1");
    endtask

    initial begin
        t_timing();
        t_sweep(0, 1050);
        t_sweep(1, 4 * 262);
        t_sweep(2, 2500);
        t_sweep(3, 8 * 312);
        t_slave();
        t_master();
        t_fmt_change();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule